// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master whose transfers are described in memory rather than pushed one word at a time. Software fills a queue of up to sixteen command entries and a 32-byte transmit RAM, picks a start and an end queue pointer, and writes the control register. The engine then walks the queue from the start pointer to the end pointer, shifting each entry's word out on `sck`/`mosi`, capturing `miso` into a 32-byte receive RAM, and keeping chip select low across entries whose continue bit is set.

The word size per entry is 8 or 16 bits, the clock polarity and phase are programmable, and the serial clock is the system clock divided by twice a programmable divider. A done flag in the status register tells software the end pointer has completed; a write of zero to the control register abandons the queue at once. Register access uses a simple single-cycle bus with a write strobe and combinational read data.

Address map (7-bit address, bits 6:5 select the region): region 0 holds the registers (0 divider, 1 mode, 2 start pointer, 3 end pointer, 4 control, 5 status, 6 current pointer); region 1 is the transmit RAM (slot = address bits 4:0, readable); region 2 is the receive RAM (read only); region 3 is the command queue (entry = address bits 3:0).

Top module: `qspi_queue_master`

## Requirements
- R1: After reset chip select (`csN`) is high, `sck` is low, the status register reads 0 and the control register reads 0 (not busy).
- R2: Each half period of `sck` lasts D system clocks, where D is the divider register value, or 8 if the value is below 8, so SCK runs at clk/(2·D).
- R3: The mode register has master enable in bit 7, word-size field in bits 5:2, CPOL in bit 1 and CPHA in bit 0; a start request while bit 7 is clear is ignored.
- R4: With `csN` high, `sck` rests at CPOL and does not toggle; `mosi` is sent MSB first and is stable at every sampling edge (leading edge when CPHA=0, trailing edge when CPHA=1), and `miso` is captured on that same edge.
- R5: An entry with command bit 6 clear, or with the word-size field non-zero, moves one byte: transmit slot 2k is sent and the received byte is written to receive slot 2k+1.
- R6: An entry with command bit 6 set while the word-size field is 0 moves a 16-bit word: transmit slot 2k then 2k+1, and the received high and low bytes go to receive slots 2k and 2k+1.
- R7: The engine processes the entries from the start pointer to the end pointer inclusive, in ascending order.
- R8: Command bit 7 (continue) set keeps chip select low into the next entry, and also after the last entry until an abort or a new start; when clear, chip select goes high for at least one half period after that entry.
- R9: A control write with bits 7 and 6 both set starts the queue; a control write of 0x00 stops the engine and releases chip select without setting done; other control values do nothing.
- R10: Status bit 0 is set when the end entry finishes and is cleared by writing 0 to the status register.
- R11: The current-pointer register shows the entry being processed; while busy (control bit 6 reads 1), writes to the configuration registers, pointers, transmit RAM and command queue are ignored.
- R12: Every fall of chip select precedes the first `sck` edge by at least one half period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 7 | Register/RAM address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Combinational read data for busAddr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| csN | output | 1 | Active-low chip select |

## Verification
The bench runs queues in all four clock modes, mixing 8-bit and 16-bit entries in one queue, so a design that mapped 8-bit receive bytes to the even slot or sent the low byte first would scramble the receive RAM. Divider values below the floor are used to catch a missing clamp, which would show as edges closer than eight clocks apart. A queue with a non-continued middle entry, and another ending on a continued entry, expose chip-select handling that either never releases between entries or drops select at the end of a queue that should stay open. An abort in mid-queue, with pointer and RAM writes issued while busy, catches an engine that lets late writes corrupt the configuration or that raises done after being stopped.

// File: rtl/qsm_pkg.sv
package qsm_pkg;
  // Serial word sizes, in bits
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  // Lowest legal half-period divider
  localparam logic [7:0] MIN_DIV = 8'd8;

  // Address regions (top two address bits)
  localparam logic [1:0] RGN_REG = 2'd0;
  localparam logic [1:0] RGN_TX  = 2'd1;
  localparam logic [1:0] RGN_RX  = 2'd2;
  localparam logic [1:0] RGN_CMD = 2'd3;

  // Register indices inside RGN_REG
  localparam logic [2:0] REG_DIV    = 3'd0;
  localparam logic [2:0] REG_MODE   = 3'd1;
  localparam logic [2:0] REG_START  = 3'd2;
  localparam logic [2:0] REG_END    = 3'd3;
  localparam logic [2:0] REG_CTRL   = 3'd4;
  localparam logic [2:0] REG_STATUS = 3'd5;
  localparam logic [2:0] REG_CURPTR = 3'd6;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadWord;   // load transmit shifter from the current entry's slots
    logic shiftBit;   // advance transmit shifter by one bit
    logic sampleBit;  // capture miso into receive shifter
    logic storeWord;  // write receive shifter into the current entry's slots
    logic setDone;    // end entry finished
  } qsmStrobe_t;
endpackage

// File: rtl/qsm_datapath.sv
module qsm_datapath
  import qsm_pkg::*;
#(
  parameter int NUM_CMD = 16,
  parameter int PTR_W   = $clog2(NUM_CMD),
  parameter int SLOT_W  = PTR_W + 1,
  parameter int ADDR_W  = SLOT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic              busy,
  input  logic [PTR_W-1:0]  curPtr,
  input  qsmStrobe_t        strobe,
  input  logic              miso,
  output logic              mosi,
  output logic              startReq,
  output logic              abortReq,
  output logic [7:0]        divEff,
  output logic              cpol,
  output logic              cpha,
  output logic              wordIs16,
  output logic              cmdCont,
  output logic [PTR_W-1:0]  startPtr,
  output logic [PTR_W-1:0]  endPtr,
  output logic              doneFlag
);
  localparam int NUM_SLOT = 2 * NUM_CMD;

  logic [7:0] txRam  [NUM_SLOT];
  logic [7:0] rxRam  [NUM_SLOT];
  logic [7:0] cmdRam [NUM_CMD];
  logic [7:0] divQ, modeQ;
  logic [WORD_W-1:0] txShift, rxShift;
  logic [1:0] region;
  logic [SLOT_W-1:0] idx, slotHi, slotLo;
  logic [7:0] cmdCur;
  logic wrOk, regHit, ctrlHit, statusHit;

  assign region    = busAddr[ADDR_W-1 -: 2];
  assign idx       = busAddr[SLOT_W-1:0];
  assign wrOk      = busWr && !busy;
  assign regHit    = busWr && (region == RGN_REG);
  assign ctrlHit   = regHit && (idx[2:0] == REG_CTRL);
  assign statusHit = regHit && (idx[2:0] == REG_STATUS);
  assign startReq  = ctrlHit && (busWdata[7:6] == 2'b11) && modeQ[7] && !busy;
  assign abortReq  = ctrlHit && (busWdata == 8'h00);

  assign cmdCur   = cmdRam[curPtr];
  assign wordIs16 = cmdCur[6] && (modeQ[5:2] == 4'd0);
  assign cmdCont  = cmdCur[7];
  assign slotHi   = {curPtr, 1'b0};
  assign slotLo   = {curPtr, 1'b1};
  assign divEff   = (divQ < MIN_DIV) ? MIN_DIV : divQ;
  assign cpol     = modeQ[1];
  assign cpha     = modeQ[0];
  assign mosi     = txShift[WORD_W-1];

  // Configuration, pointers and transmit/command storage (locked while busy)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divQ     <= '0;
      modeQ    <= '0;
      startPtr <= '0;
      endPtr   <= '0;
      for (int i = 0; i < NUM_SLOT; i++) txRam[i] <= '0;
      for (int i = 0; i < NUM_CMD; i++) cmdRam[i] <= '0;
    end else if (wrOk) begin
      unique case (region)
        RGN_REG: begin
          case (idx[2:0])
            REG_DIV:   divQ     <= busWdata;
            REG_MODE:  modeQ    <= busWdata;
            REG_START: startPtr <= busWdata[PTR_W-1:0];
            REG_END:   endPtr   <= busWdata[PTR_W-1:0];
            default: ;
          endcase
        end
        RGN_TX:  txRam[idx] <= busWdata;
        RGN_CMD: cmdRam[idx[PTR_W-1:0]] <= busWdata;
        default: ;
      endcase
    end
  end

  // Shifters, receive storage and done flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txShift  <= '0;
      rxShift  <= '0;
      doneFlag <= 1'b0;
      for (int i = 0; i < NUM_SLOT; i++) rxRam[i] <= '0;
    end else begin
      if (strobe.loadWord)
        txShift <= wordIs16 ? {txRam[slotHi], txRam[slotLo]} : {txRam[slotHi], 8'h00};
      else if (strobe.shiftBit)
        txShift <= {txShift[WORD_W-2:0], 1'b0};
      if (strobe.sampleBit)
        rxShift <= {rxShift[WORD_W-2:0], miso};
      if (strobe.storeWord) begin
        if (wordIs16) rxRam[slotHi] <= rxShift[WORD_W-1:BYTE_W];
        rxRam[slotLo] <= rxShift[BYTE_W-1:0];
      end
      if (strobe.setDone)
        doneFlag <= 1'b1;
      else if (statusHit && (busWdata == 8'h00))
        doneFlag <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (region)
      RGN_REG: begin
        case (idx[2:0])
          REG_DIV:    busRdata = divQ;
          REG_MODE:   busRdata = modeQ;
          REG_START:  busRdata = {{(8-PTR_W){1'b0}}, startPtr};
          REG_END:    busRdata = {{(8-PTR_W){1'b0}}, endPtr};
          REG_CTRL:   busRdata = {1'b0, busy, 6'b0};
          REG_STATUS: busRdata = {7'b0, doneFlag};
          REG_CURPTR: busRdata = {{(8-PTR_W){1'b0}}, curPtr};
          default:    busRdata = '0;
        endcase
      end
      RGN_TX:  busRdata = txRam[idx];
      RGN_RX:  busRdata = rxRam[idx];
      RGN_CMD: busRdata = cmdRam[idx[PTR_W-1:0]];
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/qsm_control.sv
module qsm_control
  import qsm_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startReq,
  input  logic             abortReq,
  input  logic [PTR_W-1:0] startPtr,
  input  logic [PTR_W-1:0] endPtr,
  input  logic [7:0]       divEff,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             wordIs16,
  input  logic             cmdCont,
  output qsmStrobe_t       strobe,
  output logic             busy,
  output logic [PTR_W-1:0] curPtr,
  output logic             sck,
  output logic             csActive
);
  localparam int HALF_W = $clog2(2 * WORD_W + 2);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_GAP} qsmState_t;

  qsmState_t state;
  logic [HALF_W-1:0] half, bitHalves, lastHalf;
  logic [7:0] divCnt;
  logic csHold, pendLoad, tick, runTick, inBits, wordEnd;

  // Word = lead half, 2*bits clock halves, tail half
  assign bitHalves = wordIs16 ? HALF_W'(2 * WORD_W) : HALF_W'(2 * BYTE_W);
  assign lastHalf  = bitHalves + HALF_W'(1);
  assign tick      = (divCnt == divEff - 8'd1);
  assign runTick   = (state == ST_RUN) && tick && !abortReq;
  assign wordEnd   = runTick && (half == lastHalf);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      half     <= '0;
      divCnt   <= '0;
      curPtr   <= '0;
      csHold   <= 1'b0;
      pendLoad <= 1'b0;
    end else begin
      pendLoad <= 1'b0;
      if (abortReq) begin
        state  <= ST_IDLE;
        csHold <= 1'b0;
        divCnt <= '0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            divCnt <= '0;
            if (startReq) begin
              state    <= ST_RUN;
              curPtr   <= startPtr;
              half     <= '0;
              pendLoad <= 1'b1;
            end
          end
          ST_RUN: begin
            divCnt <= tick ? '0 : divCnt + 8'd1;
            if (tick) begin
              if (half == lastHalf) begin
                half <= '0;
                if (curPtr == endPtr) begin
                  state  <= ST_IDLE;
                  csHold <= cmdCont;
                end else begin
                  curPtr <= curPtr + PTR_W'(1);
                  if (cmdCont) pendLoad <= 1'b1;
                  else         state    <= ST_GAP;
                end
              end else begin
                half <= half + HALF_W'(1);
              end
            end
          end
          ST_GAP: begin
            divCnt <= tick ? '0 : divCnt + 8'd1;
            if (tick) begin
              state    <= ST_RUN;
              pendLoad <= 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // Entering clock half j = half: odd j is the sampling edge, even j > 0 shifts
  always_comb begin
    strobe.loadWord  = pendLoad && !abortReq;
    strobe.sampleBit = runTick && (half < bitHalves) && half[0];
    strobe.shiftBit  = runTick && (half < bitHalves) && !half[0] && (half != '0);
    strobe.storeWord = wordEnd;
    strobe.setDone   = wordEnd && (curPtr == endPtr);
  end

  assign busy     = (state != ST_IDLE);
  assign csActive = (state == ST_RUN) || ((state == ST_IDLE) && csHold);
  assign inBits   = (state == ST_RUN) && (half != '0) && (half <= bitHalves);
  assign sck      = inBits ? (cpol ^ (half[0] ~^ cpha)) : cpol;
endmodule

// File: rtl/qspi_queue_master.sv
module qspi_queue_master
  import qsm_pkg::*;
#(
  parameter int NUM_CMD = 16,
  parameter int PTR_W   = $clog2(NUM_CMD),
  parameter int SLOT_W  = PTR_W + 1,
  parameter int ADDR_W  = SLOT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              csN
);
  qsmStrobe_t strobe;
  logic busy, startReq, abortReq, cpolW, cphaW, wordIs16, cmdCont, csActive, doneFlag;
  logic [7:0] divEff;
  logic [PTR_W-1:0] curPtr, startPtr, endPtr;

  qsm_datapath #(.NUM_CMD(NUM_CMD), .PTR_W(PTR_W), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busy(busy), .curPtr(curPtr), .strobe(strobe), .miso(miso),
    .mosi(mosi), .startReq(startReq), .abortReq(abortReq), .divEff(divEff),
    .cpol(cpolW), .cpha(cphaW), .wordIs16(wordIs16), .cmdCont(cmdCont),
    .startPtr(startPtr), .endPtr(endPtr), .doneFlag(doneFlag)
  );

  qsm_control #(.PTR_W(PTR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .abortReq(abortReq),
    .startPtr(startPtr), .endPtr(endPtr), .divEff(divEff), .cpol(cpolW), .cpha(cphaW),
    .wordIs16(wordIs16), .cmdCont(cmdCont), .strobe(strobe), .busy(busy),
    .curPtr(curPtr), .sck(sck), .csActive(csActive)
  );

  assign csN = !csActive;
endmodule

// File: rtl/qsm_checker.sv
module qsm_checker #(
  parameter int PTR_W  = 4,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [7:0]        busWdata,
  input logic              sck,
  input logic              mosi,
  input logic              csN,
  input logic              cpol,
  input logic              cpha,
  input logic              busy,
  input logic              doneFlag,
  input logic [PTR_W-1:0]  startPtr
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  logic ctrlZeroWr, startWr;
  assign ctrlZeroWr = busWr && (busAddr == ADDR_W'(4)) && (busWdata == 8'h00);
  assign startWr    = busWr && (busAddr == ADDR_W'(2));

  // R4: deselected bus keeps sck at its idle level
  assert_idle_sck_R4: assert property (@(posedge clk) disable iff (!rst_n)
    csN |-> (sck == cpol));

  // R4: data is steady across each sampling edge
  assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !csN && !$past(csN) && (sck != $past(sck)) && ((sck ^ cpol) != cpha))
      |-> (mosi == $past(mosi)));

  // R10: done rises only as the engine goes idle
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $rose(doneFlag)) |-> !busy);

  // R9: a zero control write stops the engine and releases select
  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlZeroWr |=> (!busy && csN));

  // R11: start pointer cannot change while busy
  assert_ptr_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && startWr) |=> $stable(startPtr));
endmodule

bind qspi_queue_master qsm_checker #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
  .sck(sck), .mosi(mosi), .csN(csN), .cpol(cpolW), .cpha(cphaW), .busy(busy),
  .doneFlag(doneFlag), .startPtr(startPtr)
);

// File: tb/qspi_queue_master_bench.sv
module qspi_queue_master_bench;
  logic clk = 0, rst_n = 0, busWr = 0, miso = 1;
  logic [6:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic sck, mosi, csN;

  always #5 clk = ~clk;

  qspi_queue_master u_qspi_queue_master (
    .clk(clk), .rst_n(rst_n), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .sck(sck), .mosi(mosi), .miso(miso), .csN(csN)
  );

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] txMem [32];
  logic [7:0] cmdMem [16];
  logic [7:0] respArr [64];
  logic [7:0] gotMosi [$];

  // Behavioural slave and line monitor, evaluated every clock
  bit monOn = 0, expCpol = 0, expCpha = 0, firstEdge = 0;
  logic prevSck = 0, prevCs = 1;
  logic [7:0] shIn = '0;
  int expHalf = 8, bitCnt = 0, csFall = 0, lastEdge = 0, minSp = 0, sp = 0;
  int csFalls = 0, monErr = 0, firstErr = 0;

  always @(posedge clk) cyc++;

  function automatic logic respBit(int n);
    if (n / 8 >= 64) return 1'b1;
    return respArr[n / 8][7 - (n % 8)];
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (monOn && csN && (sck !== expCpol)) monErr++;
      if (!csN && prevCs) begin csFall = cyc; csFalls++; firstEdge = 1; end
      if (!csN && (sck !== prevSck)) begin
        if (firstEdge) begin
          sp = cyc - csFall;
          if (sp < expHalf) firstErr++;
        end else begin
          sp = cyc - lastEdge;
          if (sp < minSp) minSp = sp;
        end
        firstEdge = 0;
        lastEdge = cyc;
        if ((sck ^ expCpol) != expCpha) begin
          shIn = {shIn[6:0], mosi};
          bitCnt++;
          if (bitCnt % 8 == 0) gotMosi.push_back(shIn);
        end
      end
      miso = respBit(bitCnt);
      prevSck = sck;
      prevCs = csN;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    busWr = 1; busAddr = 7'(a); busWdata = d;
    @(negedge clk);
    busWr = 0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    busAddr = 7'(a);
    #1 d = busRdata;
  endtask

  task automatic loadQueue(input logic [7:0] mode, input logic [7:0] div, input int s, input int e);
    wr(0, div); wr(1, mode); wr(2, 8'(s)); wr(3, 8'(e));
    for (int k = s; k <= e; k++) wr(96 + k, cmdMem[k]);
    for (int i = 0; i < 32; i++) wr(32 + i, txMem[i]);
  endtask

  task automatic waitDone(output logic [7:0] st);
    st = '0;
    for (int i = 0; i < 20000; i++) begin
      rd(5, st);
      if (st[0]) break;
    end
  endtask

  task automatic doXfer(input logic [7:0] mode, input logic [7:0] div, input int s, input int e, input int seed);
    logic [7:0] expM [$];
    logic [7:0] expRx [32];
    bit touched [32];
    logic [7:0] v;
    int ri, expFalls, m0, f0;
    bit is16;
    for (int i = 0; i < 32; i++) begin txMem[i] = 8'(i * 29 + seed); touched[i] = 0; expRx[i] = '0; end
    for (int i = 0; i < 64; i++) respArr[i] = 8'(i * 53 + seed * 7 + 1);
    monOn = 0;
    loadQueue(mode, div, s, e);
    expCpol = mode[1]; expCpha = mode[0];
    expHalf = (div < 8) ? 8 : int'(div);
    gotMosi.delete();
    bitCnt = 0; minSp = 1000000; csFalls = 0; m0 = monErr; f0 = firstErr;
    ri = 0; expFalls = 1;
    for (int k = s; k <= e; k++) begin
      is16 = cmdMem[k][6] && (mode[5:2] == 4'd0);
      expM.push_back(txMem[2*k]);
      if (is16) begin
        expM.push_back(txMem[2*k+1]);
        expRx[2*k] = respArr[ri]; expRx[2*k+1] = respArr[ri+1];
        touched[2*k] = 1; touched[2*k+1] = 1; ri += 2;
      end else begin
        expRx[2*k+1] = respArr[ri]; touched[2*k+1] = 1; ri++;
      end
      if (k < e && !cmdMem[k][7]) expFalls++;
    end
    wr(5, 8'h00);
    @(negedge clk); monOn = 1;
    wr(4, 8'hC0);
    waitDone(v);
    chk(v[0] == 1'b1, "R10 done after end entry", v[0], 1);
    // R7: all entries start..end, in order
    chk(gotMosi.size() == expM.size(), "R7 byte count", gotMosi.size(), expM.size());
    for (int i = 0; i < expM.size() && i < gotMosi.size(); i++)
      chk(gotMosi[i] == expM[i], "R5/R6 mosi byte order", gotMosi[i], expM[i]);
    for (int i = 0; i < 32; i++)
      if (touched[i]) begin
        rd(64 + i, v);
        chk(v == expRx[i], (i % 2 == 0) ? "R6 rx high slot" : "R5 rx odd slot", v, expRx[i]);
      end
    chk(minSp == expHalf, "R2 half period", minSp, expHalf);
    chk(monErr == m0, "R4 idle sck level", monErr - m0, 0);
    chk(firstErr == f0, "R12 select to first edge", firstErr - f0, 0);
    chk(csFalls == expFalls, "R8 select falls", csFalls, expFalls);
    monOn = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(csN == 1'b1, "R1 cs idle", csN, 1);
    chk(sck == 1'b0, "R1 sck idle", sck, 0);
    rd(5, v); chk(v == 8'h00, "R1 status", v, 0);
    rd(4, v); chk(v == 8'h00, "R1 control", v, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // Mode 0, 8-bit entries, last one releases select
    cmdMem[0] = 8'h82; cmdMem[1] = 8'h82; cmdMem[2] = 8'h82; cmdMem[3] = 8'h02;
    doXfer(8'hA0, 8'd8, 0, 3, 3);
    chk(csN == 1'b1, "R8 select released at end", csN, 1);
    wr(5, 8'h00); rd(5, v);
    chk(v == 8'h00, "R10 status cleared", v, 0);

    // Mode 3, mixed 16-bit and 8-bit entries
    cmdMem[2] = 8'hC2; cmdMem[3] = 8'h82; cmdMem[4] = 8'hC2; cmdMem[5] = 8'h42;
    doXfer(8'h83, 8'd10, 2, 5, 11);

    // Mode 1, divider below floor, 16-bit flag with 8-bit size, mid-queue release
    cmdMem[5] = 8'h02; cmdMem[6] = 8'hC2; cmdMem[7] = 8'h02;
    doXfer(8'hA1, 8'd3, 5, 7, 21);

    // Mode 2, last entry keeps select low until abort
    cmdMem[14] = 8'hC2; cmdMem[15] = 8'hC2;
    doXfer(8'h82, 8'd9, 14, 15, 5);
    chk(csN == 1'b0, "R8 select held after continued end", csN, 0);
    wr(4, 8'h00);
    chk(csN == 1'b1, "R9 abort releases select", csN, 1);

    // Abort in mid-queue; writes while busy are ignored
    for (int k = 0; k < 16; k++) cmdMem[k] = 8'h82;
    loadQueue(8'hA0, 8'd20, 0, 15);
    wr(5, 8'h00);
    wr(4, 8'hC0);
    repeat (900) @(negedge clk);
    rd(6, v); chk(v == 8'd2, "R11 current pointer", v, 2);
    rd(4, v); chk(v == 8'h40, "R11 busy flag", v, 8'h40);
    wr(2, 8'd9); wr(32, 8'h55); wr(0, 8'd40);
    wr(4, 8'h00);
    rd(2, v); chk(v == 8'd0, "R11 start pointer locked", v, 0);
    rd(32, v); chk(v == txMem[0], "R11 tx slot locked", v, txMem[0]);
    rd(0, v); chk(v == 8'd20, "R11 divider locked", v, 20);
    rd(5, v); chk(v == 8'h00, "R9 abort leaves done clear", v, 0);
    rd(4, v); chk(v == 8'h00, "R9 abort idles engine", v, 0);
    chk(csN == 1'b1, "R9 abort select high", csN, 1);

    // Start ignored without master enable, and with only bit 6
    wr(1, 8'h20); wr(4, 8'hC0);
    rd(4, v); chk(v == 8'h00, "R3 start needs master enable", v, 0);
    chk(csN == 1'b1, "R3 select stays high", csN, 1);
    wr(1, 8'hA0); wr(4, 8'h40);
    rd(4, v); chk(v == 8'h00, "R9 partial control ignored", v, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule